// File: doc/BRIEF.md
# Timer Capture and Compare Unit

This unit sits beside a free-running 16-bit timer and serves one I/O pin. A 4-bit mode code selects what it does. In a capture mode, a chosen pin edge takes a snapshot of the timer into two 8-bit holding registers and raises a sticky event flag. In a compare mode, the same two registers form a 16-bit target. When the timer reaches the target, the unit can drive the pin high or low, raise only the flag, or fire a special trigger. The special trigger clears the timer and starts an external conversion.

Software programs the unit through a plain single-cycle write strobe that selects the mode register, the low byte or the high byte. No data stream crosses the unit's edge, so there is no valid/ready handshake and no back-pressure. Every write is accepted in the cycle it is presented. The pin input is resynchronised before edges are detected. Mode codes reserved for pulse-width generation leave this unit idle.

Top module: `ccp_unit`

## Requirements
- R1: Mode codes 0000 to 0011 are off. In these modes, pin edges and timer matches neither raise `irq_flag` nor move `pin_out`, and `pin_ie` and `pin_oe` are both low.
- R2: Code 0100 captures on every falling pin edge and code 0101 captures on every rising edge. `pin_ie` is high for all codes 01xx.
- R3: A capture loads `tmr_val[7:0]` into `cap_lo` and `tmr_val[15:8]` into `cap_hi`, and sets `irq_flag` on the same clock edge. If a register write arrives in the same cycle, the capture wins.
- R4: Codes 0110 and 0111 count rising edges with a down-counter. On a rising edge, if the counter is 1 or 0, the unit captures and reloads the counter with 4 (code 0110) or 16 (code 0111). Otherwise the counter decrements by one.
- R5: Writing mode 0100 or 0101 clears the edge counter. Writing 0110 keeps only the counter's low two bits. Writing 0111 leaves the counter unchanged.
- R6: On a match, code 1000 drives `pin_out` high and code 1001 drives it low. Code 1010 leaves `pin_out` unchanged. All three set the flag, and `pin_oe` is high for codes 10xx.
- R7: On a match, code 1011 sets the flag and issues one-cycle pulses on `tmr_clear` and `conv_start` in the cycle after the match edge.
- R8: In a compare mode, a match fires once when `tmr_val` equals `{cap_hi,cap_lo}`. It does not fire again while that equality persists. Any register write re-arms the match against the new 16-bit value.
- R9: A timer match is ignored in capture modes. Codes 11xx disable both capture and compare, with `pin_ie` and `pin_oe` low.
- R10: The captured value is the `tmr_val` present at the third rising clock edge after the pin changes, because of the two-flop synchroniser and the edge detector.
- R11: `irq_flag` stays set until a `flag_clr` pulse clears it. If a new event arrives in the same cycle as a clear, the flag stays set.
- R12: `wr_sel` selects the write target: 0 is the mode (`wr_data[3:0]`), 1 is the low byte, 2 is the high byte and 3 is nothing. After reset, the mode is 0000, both bytes are 0, and the flag and `pin_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clears the event flag |
| tmr_val | input | 16 | Current timer count |
| pin_in | input | 1 | Asynchronous pin level |
| cap_lo | output | 8 | Low holding register |
| cap_hi | output | 8 | High holding register |
| irq_flag | output | 1 | Sticky event flag |
| pin_out | output | 1 | Compare output level |
| pin_oe | output | 1 | Pin output enable |
| pin_ie | output | 1 | Pin input enable |
| tmr_clear | output | 1 | Timer reset pulse |
| conv_start | output | 1 | Conversion start pulse |

## Verification
The hardest state to reach from the ports is the edge counter holding a mid-count value at the moment the mode changes. The counter itself is invisible, so its value must be inferred from the edge on which the next capture lands. The stimulus first runs the every-4th mode through three captures. It then switches to every-16th mode and takes a capture followed by three extra edges. Finally it switches back to every-4th mode, where the low-two-bit truncation makes the very next edge capture. Each expected capture is queued with a distinct frozen timer value, so an early or late capture shows up as a wrong value or a leftover queue entry.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int TMR_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } ccp_sel_e;

  localparam logic [3:0] M_CAP_FALL  = 4'b0100;
  localparam logic [3:0] M_CAP_RISE  = 4'b0101;
  localparam logic [3:0] M_CAP_DIV_A = 4'b0110;
  localparam logic [3:0] M_CAP_DIV_B = 4'b0111;
  localparam logic [3:0] M_CMP_SET   = 4'b1000;
  localparam logic [3:0] M_CMP_CLR   = 4'b1001;
  localparam logic [3:0] M_CMP_IRQ   = 4'b1010;
  localparam logic [3:0] M_CMP_TRIG  = 4'b1011;

  function automatic logic mode_is_off(input logic [3:0] m);
    return m[3:2] == 2'b00;
  endfunction

  function automatic logic mode_is_cap(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic mode_is_cmp(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/ccp_sync_edge.sv
module ccp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // chain[0..STAGES-1] is the synchroniser; chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       mode_wr,
  input  logic [3:0] mode_new,
  input  logic       rise,
  input  logic       fall,
  output logic       fire
);
  localparam int CNT_W = $clog2(DIV_B + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             due;
  logic             divided;

  assign due     = cnt_q <= CNT_W'(1);
  assign divided = (mode == M_CAP_DIV_A) || (mode == M_CAP_DIV_B);

  always_comb begin
    case (mode)
      M_CAP_FALL:  fire = fall;
      M_CAP_RISE:  fire = rise;
      M_CAP_DIV_A,
      M_CAP_DIV_B: fire = rise && due;
      default:     fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (mode_wr) begin
      if (mode_new == M_CAP_FALL || mode_new == M_CAP_RISE)
        cnt_q <= '0;
      else if (mode_new == M_CAP_DIV_A)
        cnt_q <= cnt_q & CNT_W'(DIV_A - 1);
    end else if (divided && rise) begin
      if (due) cnt_q <= (mode == M_CAP_DIV_A) ? CNT_W'(DIV_A) : CNT_W'(DIV_B);
      else     cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DIV_B));
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] tmr_val,
  input  logic         rearm,
  output logic         hit,
  output logic         drive_hi,
  output logic         drive_lo,
  output logic         trig
);
  logic match;
  logic seen_q;
  logic trig_q;

  assign match    = mode_is_cmp(mode) && (tmr_val == cmp_val);
  assign hit      = match && !seen_q;
  assign drive_hi = hit && (mode == M_CMP_SET);
  assign drive_lo = hit && (mode == M_CMP_CLR);
  assign trig     = trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      seen_q <= rearm ? 1'b0 : match;
      trig_q <= hit && (mode == M_CMP_TRIG);
    end
  end

  assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rearm) |=> !hit);
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  input  logic [TMR_W-1:0]  tmr_val,
  input  logic              pin_in,
  output logic [BYTE_W-1:0] cap_lo,
  output logic [BYTE_W-1:0] cap_hi,
  output logic              irq_flag,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              pin_ie,
  output logic              tmr_clear,
  output logic              conv_start
);
  ccp_sel_e          sel;
  logic [3:0]        mode_q;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              irq_q, pin_q;
  logic              rise, fall, cap_fire;
  logic              hit, drive_hi, drive_lo, trig;
  logic              mode_wr, rearm;

  assign sel     = ccp_sel_e'(wr_sel);
  assign mode_wr = wr_en && (sel == SEL_MODE);
  assign rearm   = wr_en && (sel != SEL_NONE);

  ccp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .rise(rise), .fall(fall)
  );

  ccp_capture #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .mode_wr(mode_wr),
    .mode_new(wr_data[3:0]), .rise(rise), .fall(fall), .fire(cap_fire)
  );

  ccp_compare #(.W(TMR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .cmp_val({hi_q, lo_q}),
    .tmr_val(tmr_val), .rearm(rearm), .hit(hit), .drive_hi(drive_hi),
    .drive_lo(drive_lo), .trig(trig)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      irq_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= wr_data[3:0];
      if (cap_fire) begin
        lo_q <= tmr_val[BYTE_W-1:0];
        hi_q <= tmr_val[TMR_W-1:BYTE_W];
      end else if (wr_en) begin
        if (sel == SEL_LO) lo_q <= wr_data;
        if (sel == SEL_HI) hi_q <= wr_data;
      end
      if (cap_fire || hit) irq_q <= 1'b1;
      else if (flag_clr)   irq_q <= 1'b0;
      if (drive_hi)      pin_q <= 1'b1;
      else if (drive_lo) pin_q <= 1'b0;
    end
  end

  assign cap_lo     = lo_q;
  assign cap_hi     = hi_q;
  assign irq_flag   = irq_q;
  assign pin_out    = pin_q;
  assign pin_oe     = mode_is_cmp(mode_q);
  assign pin_ie     = mode_is_cap(mode_q);
  assign tmr_clear  = trig;
  assign conv_start = trig;

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_off(mode_q) |=> !$rose(irq_q));

  assert_cap_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && $past(mode_is_cap(mode_q))) |-> ({hi_q, lo_q} == $past(tmr_val)));

  assert_pin_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_q) |-> ($past(mode_q) == M_CMP_SET));

  assert_trig_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> irq_q);

  assert_cmp_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && $past(mode_is_cmp(mode_q))) |-> $past(tmr_val == {hi_q, lo_q}));
endmodule

// File: tb/tb_ccp_unit.sv
module tb_ccp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [7:0]  wr_data = '0;
  logic        flag_clr = 1'b0;
  logic [15:0] tmr = '0;
  logic        pin_in = 1'b0;
  logic [7:0]  cap_lo, cap_hi;
  logic        irq_flag, pin_out, pin_oe, pin_ie, tmr_clear, conv_start;

  logic        run = 1'b0, ld = 1'b0;
  logic [15:0] ld_val = '0;
  int          checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  logic        irq_prev = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ccp_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_clr(flag_clr), .tmr_val(tmr), .pin_in(pin_in), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .irq_flag(irq_flag), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_ie(pin_ie), .tmr_clear(tmr_clear), .conv_start(conv_start)
  );

  // timer model honouring the clear pulse
  always @(posedge clk) begin
    if (ld)             tmr <= ld_val;
    else if (tmr_clear) tmr <= '0;
    else if (run)       tmr <= tmr + 16'd1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every new flag event must match the next queued value
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (irq_flag && !irq_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected flag event", {cap_hi, cap_lo}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({cap_hi, cap_lo} == e, "R3 event register value", {cap_hi, cap_lo}, e);
        end
      end
      irq_prev = irq_flag;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic load(input logic [15:0] v, input logic r);
    @(negedge clk); ld = 1'b1; ld_val = v; run = r;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v, input bit fire, input string req);
    load(v, 1'b0);
    if (fire) exp_q.push_back(v);
    pin_in = 1'b1; tick(5);
    pin_in = 1'b0; tick(5);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    if (irq_flag) clr();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    // R12 reset state
    chk({cap_hi, cap_lo} == 16'h0, "R12 reset registers", {cap_hi, cap_lo}, 0);
    chk({irq_flag, pin_out, pin_oe, pin_ie, conv_start, tmr_clear} == 6'b0, "R12 reset outputs",
        {irq_flag, pin_out, pin_oe, pin_ie, conv_start, tmr_clear}, 0);

    // R12 write port, R1 off mode
    wr(2'd1, 8'h34); wr(2'd2, 8'h12); wr(2'd3, 8'hFF);
    chk({cap_hi, cap_lo} == 16'h1234, "R12 byte writes", {cap_hi, cap_lo}, 16'h1234);
    wr(2'd0, 8'h03);
    pulse(16'h1234, 1'b0, "R1 off mode ignores edges and matches");
    chk({pin_oe, pin_ie, pin_out} == 3'b0, "R1 off mode pin enables", {pin_oe, pin_ie, pin_out}, 0);

    // R2 rising and falling capture
    wr(2'd0, 8'h05);
    chk(pin_ie == 1'b1 && pin_oe == 1'b0, "R2 capture input enable", {pin_oe, pin_ie}, 2'b01);
    pulse(16'h1111, 1'b1, "R2 rising capture");
    wr(2'd0, 8'h04);
    pulse(16'h2222, 1'b1, "R2 falling capture");

    // R10 latency with running timer
    wr(2'd0, 8'h05);
    load(16'h4000, 1'b1);
    exp_q.push_back(tmr + 16'd2);
    pin_in = 1'b1; tick(6);
    chk(exp_q.size() == 0, "R10 capture latency", exp_q.size(), 0);
    exp_q.delete();
    pin_in = 1'b0; tick(4); clr();

    // R11 sticky flag
    load(16'h3333, 1'b0);
    exp_q.push_back(16'h3333);
    pin_in = 1'b1; tick(6);
    chk(irq_flag == 1'b1, "R11 flag set", irq_flag, 1);
    tick(20);
    chk(irq_flag == 1'b1, "R11 flag sticky", irq_flag, 1);
    clr(); tick(1);
    chk(irq_flag == 1'b0, "R11 flag cleared", irq_flag, 0);
    pin_in = 1'b0; tick(4);

    // R4 every-4th from a cleared counter: edges 1,5,9 capture
    wr(2'd0, 8'h06);
    for (int k = 1; k <= 9; k++)
      pulse(16'hA000 + 16'(k), (k == 1) || (k == 5) || (k == 9), "R4 every-4th rising");
    // R5 every-16th keeps counter 4: fourth edge captures
    wr(2'd0, 8'h07);
    for (int k = 1; k <= 7; k++)
      pulse(16'hB000 + 16'(k), (k == 4), "R5 every-16th keeps count");
    // counter now 13; every-4th keeps low bits -> 1 -> next edge captures
    wr(2'd0, 8'h06);
    pulse(16'hC001, 1'b1, "R5 every-4th truncates count");
    pulse(16'hC002, 1'b0, "R4 reload after capture");

    // R6 compare set / interrupt only / clear
    load(16'h0000, 1'b0);
    wr(2'd0, 8'h08); wr(2'd1, 8'h34); wr(2'd2, 8'h02);
    chk(pin_oe == 1'b1 && pin_ie == 1'b0, "R6 compare output enable", {pin_oe, pin_ie}, 2'b10);
    exp_q.push_back(16'h0234);
    load(16'h0230, 1'b1); tick(10);
    chk(pin_out == 1'b1, "R6 set output on match", pin_out, 1);
    clr(); load(16'h0000, 1'b0);
    wr(2'd0, 8'h0A);
    exp_q.push_back(16'h0234);
    load(16'h0230, 1'b1); tick(10);
    chk(irq_flag == 1'b1 && pin_out == 1'b1, "R6 interrupt-only keeps pin", {irq_flag, pin_out}, 2'b11);
    clr(); load(16'h0000, 1'b0);
    wr(2'd0, 8'h09);
    exp_q.push_back(16'h0234);
    load(16'h0230, 1'b1); tick(10);
    chk(pin_out == 1'b0, "R6 clear output on match", pin_out, 0);
    clr();

    // R8 single fire and re-arm with a frozen timer
    load(16'h0300, 1'b0);
    wr(2'd0, 8'h0A);
    exp_q.push_back(16'h0300);
    wr(2'd1, 8'h00); wr(2'd2, 8'h03); tick(3);
    chk(exp_q.size() == 0, "R8 match fires", exp_q.size(), 0);
    clr(); tick(10);
    chk(irq_flag == 1'b0, "R8 no refire while equal", irq_flag, 0);
    exp_q.push_back(16'h0300);
    wr(2'd1, 8'h00); tick(3);
    chk(exp_q.size() == 0, "R8 write re-arms match", exp_q.size(), 0);
    exp_q.delete(); clr();

    // R7 special trigger
    load(16'h0000, 1'b0);
    wr(2'd0, 8'h0B); wr(2'd1, 8'h05); wr(2'd2, 8'h01);
    exp_q.push_back(16'h0105);
    load(16'h0100, 1'b1);
    begin
      int n_conv = 0, n_clr = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (conv_start) n_conv++;
        if (tmr_clear) n_clr++;
      end
      chk(n_conv == 1, "R7 conversion pulse count", n_conv, 1);
      chk(n_clr == 1, "R7 timer clear pulse count", n_clr, 1);
      chk(tmr < 16'h0040, "R7 timer restarted", tmr, 16'h0030);
    end
    chk(exp_q.size() == 0, "R7 trigger flag", exp_q.size(), 0);
    exp_q.delete(); clr();

    // R9 capture mode ignores match, 11xx disables all
    load(16'h0000, 1'b0);
    wr(2'd0, 8'h05);
    load({cap_hi, cap_lo}, 1'b0); tick(10);
    chk(irq_flag == 1'b0, "R9 match ignored in capture", irq_flag, 0);
    wr(2'd0, 8'h0C);
    chk({pin_oe, pin_ie} == 2'b00, "R9 disabled pin enables", {pin_oe, pin_ie}, 0);
    pulse({cap_hi, cap_lo}, 1'b0, "R9 disabled codes ignore edges and match");

    tick(5);
    finish_run();
  end
endmodule